// File: doc/BRIEF.md
# Multi-Row Page Erase Sequencer

This block runs a multi-row erase of a paged storage array, one row per cycle of a row clock that it generates itself. A single-cycle erase strobe arrives with a row address. The block ignores the block-offset bits and starts erasing that row. It keeps stepping to the next row at the end of every row-clock cycle until the host gives a stop strobe. The erase length is never passed as a count. The host counts row-clock pulses on `row_clk` and sends the stop before the row it wants to be the last one has finished. The stop takes effect when the row in progress ends.

The row-clock period, and the low pulse at the end of each row, follow the 2-bit rate code. The code is captured when the erase starts. The timing unit is `BASE` clock cycles, so one unit is 31.25 µs of real time. At rate code 0 a row lasts 40 units (1.25 ms), with a low pulse of 8 units (0.25 ms). The block has no path for serial commands. A serial front end decodes the commands and delivers them here as strobes, and the bus stays free while an erase runs.

When the erase finishes, the block latches one of two causes: a normal stop (end of message) or running off the last row (overflow). It then drives the active-low interrupt, which stays low until a status-read strobe clears it.

Top module: `page_erase_seq`

## Requirements
- R1: After reset, `busy` is 0, `row_clk` is 1, `int_n` is 1, `cur_row` is 0 and both flags are 0.
- R2: An `erase_req` seen while idle sets `busy` on the next clock edge and loads `cur_row` with `erase_addr[PAGE_W+BLK_W-1:BLK_W]`. The low `BLK_W` bits are ignored.
- R3: Every row lasts P cycles and ends with a low pulse of L cycles on `row_clk`. The pair (P, L) is BASE times (40,8), (50,10), (60,12) or (80,16) for rate codes 0, 1, 2 and 3. The code is captured at the erase start, so later changes have no effect. `row_clk` is 1 while idle.
- R4: At the clock edge that ends a row's low pulse, `cur_row` increases by exactly one.
- R5: A `stop_req` during an erase ends it at the end of the row in progress, including a stop seen in a row's last cycle. `busy` falls, `cur_row` keeps the last erased row, `flag_eom` is set and `int_n` goes low.
- R6: If the last row (all ones) ends with no stop pending, the erase ends. `cur_row` stays at the last row, `flag_ovf` is set and `int_n` goes low. A stop pending in that row gives end of message instead.
- R7: A `status_rd` strobe clears both flags and returns `int_n` to 1. Without it, `int_n` stays low.
- R8: An `erase_req` during an erase and a `stop_req` while idle are both ignored. A stop while idle leaves nothing latched for the next erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Rate code, captured at erase start |
| erase_req | input | 1 | Erase command strobe |
| erase_addr | input | PAGE_W+BLK_W | Row address; the low BLK_W bits are the ignored block offset |
| stop_req | input | 1 | Stop command strobe |
| status_rd | input | 1 | Status-read strobe; clears the interrupt |
| row_clk | output | 1 | Row clock, low for the last L cycles of each row |
| busy | output | 1 | Erase in progress |
| cur_row | output | PAGE_W | Row being erased, or the last one erased |
| int_n | output | 1 | Active-low interrupt |
| flag_eom | output | 1 | Erase ended by a stop |
| flag_ovf | output | 1 | Erase ran past the last row |

## Verification
The bench builds the block with BASE = 1 and PAGE_W = 4. Rows then last 40 to 80 cycles, and the array has only 16 rows. That makes it possible to reach the overflow at the last row from random start rows, and to compare every single cycle of `row_clk` against the model. Stops land at random cycles, including the last cycle of a row. The rate code is flipped in mid-erase to show it was captured at the start.

// File: rtl/page_erase_pkg.sv
package page_erase_pkg;
  localparam int unsigned RATE_W = 2;

  // Row period in timing units (one unit = 1/32 ms).
  function automatic int unsigned row_units(input logic [RATE_W-1:0] code);
    case (code)
      2'd0:    return 40;
      2'd1:    return 50;
      2'd2:    return 60;
      default: return 80;
    endcase
  endfunction

  // Low pulse length: one fifth of the period at every rate.
  function automatic int unsigned low_units(input logic [RATE_W-1:0] code);
    return row_units(code) / 5;
  endfunction
endpackage

// File: rtl/erase_row_timer.sv
module erase_row_timer
  import page_erase_pkg::*;
#(
  parameter int unsigned BASE  = 1000,
  parameter int unsigned CNT_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              row_clk,
  output logic              row_end
);
  logic [CNT_W-1:0] per_q, low_q, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      low_q <= '0;
      cnt   <= '0;
    end else if (start) begin
      per_q <= CNT_W'(row_units(rate) * BASE);
      low_q <= CNT_W'(low_units(rate) * BASE);
      cnt   <= '0;
    end else if (run) begin
      cnt <= (cnt == per_q - 1'b1) ? '0 : cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  assign row_end = run && (cnt == per_q - 1'b1);
  assign row_clk = !(run && (cnt >= per_q - low_q));

  // A row only ends while its low pulse is being driven.
  p_low_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |-> !row_clk);
  // The captured timing holds for the whole erase.
  p_rate_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> $stable(per_q) && $stable(low_q));
endmodule

// File: rtl/erase_row_ctr.sv
module erase_row_ctr #(
  parameter int unsigned PAGE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              advance,
  output logic [PAGE_W-1:0] row,
  output logic              at_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row <= '0;
    else if (start)   row <= page_in;
    else if (advance) row <= row + 1'b1;
  end

  assign at_last = &row;

  p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !start) |=> row == $past(row) + 1'b1);
  p_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !start) |=> $stable(row));
endmodule

// File: rtl/erase_irq.sv
module erase_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_eom,
  input  logic set_ovf,
  input  logic clr,
  output logic int_n,
  output logic eom_f,
  output logic ovf_f
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      eom_f  <= 1'b0;
      ovf_f  <= 1'b0;
    end else begin
      pend_q <= set_eom || set_ovf || (pend_q && !clr);
      eom_f  <= set_eom || (eom_f && !clr);
      ovf_f  <= set_ovf || (ovf_f && !clr);
    end
  end

  assign int_n = !pend_q;

  p_int_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_eom || set_ovf) |=> !int_n);
  p_int_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && !clr) |=> !int_n);
  p_int_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_eom && !set_ovf) |=> int_n && !eom_f && !ovf_f);
endmodule

// File: rtl/page_erase_seq.sv
module page_erase_seq
  import page_erase_pkg::*;
#(
  parameter int unsigned BASE   = 1000,
  parameter int unsigned PAGE_W = 11,
  parameter int unsigned BLK_W  = 5,
  localparam int unsigned ADDR_W = PAGE_W + BLK_W,
  localparam int unsigned CNT_W  = $clog2(80 * BASE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] erase_addr,
  input  logic              stop_req,
  input  logic              status_rd,
  output logic              row_clk,
  output logic              busy,
  output logic [PAGE_W-1:0] cur_row,
  output logic              int_n,
  output logic              flag_eom,
  output logic              flag_ovf
);
  logic start, row_end, at_last, stop_pend, stop_now;
  logic end_stop, end_ovf, advance;

  assign start    = erase_req && !busy;
  assign stop_now = stop_pend || stop_req;
  assign end_stop = row_end && stop_now;
  assign end_ovf  = row_end && !stop_now && at_last;
  assign advance  = row_end && !stop_now && !at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      stop_pend <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      stop_pend <= 1'b0;
    end else if (end_stop || end_ovf) begin
      busy      <= 1'b0;
      stop_pend <= 1'b0;
    end else if (busy && stop_req) begin
      stop_pend <= 1'b1;
    end
  end

  erase_row_timer #(.BASE(BASE), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
    .rate(rate_sel), .row_clk(row_clk), .row_end(row_end)
  );

  erase_row_ctr #(.PAGE_W(PAGE_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .start(start),
    .page_in(erase_addr[ADDR_W-1:BLK_W]), .advance(advance),
    .row(cur_row), .at_last(at_last)
  );

  erase_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_eom(end_stop), .set_ovf(end_ovf),
    .clr(status_rd), .int_n(int_n), .eom_f(flag_eom), .ovf_f(flag_ovf)
  );

  p_idle_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !erase_req) |=> !busy);
  p_busy_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_req && !row_end) |=> $stable(cur_row));
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && erase_req) |=> busy && cur_row == $past(erase_addr[ADDR_W-1:BLK_W]));
  p_idle_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> row_clk);
  p_end_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (flag_eom != flag_ovf));
endmodule

// File: tb/sim_page_erase_seq.sv
module sim_page_erase_seq;
  localparam int unsigned BASE = 1, PAGE_W = 4, BLK_W = 5;
  localparam int unsigned LASTP = (1 << PAGE_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic erase_req = 1'b0, stop_req = 1'b0, status_rd = 1'b0;
  logic [PAGE_W+BLK_W-1:0] erase_addr = '0;
  logic row_clk, busy, int_n, flag_eom, flag_ovf;
  logic [PAGE_W-1:0] cur_row;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  page_erase_seq #(.BASE(BASE), .PAGE_W(PAGE_W), .BLK_W(BLK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .erase_req(erase_req),
    .erase_addr(erase_addr), .stop_req(stop_req), .status_rd(status_rd),
    .row_clk(row_clk), .busy(busy), .cur_row(cur_row), .int_n(int_n),
    .flag_eom(flag_eom), .flag_ovf(flag_ovf));

  function automatic int per_of(input logic [1:0] r);
    case (r) 2'd0: return 40*BASE; 2'd1: return 50*BASE;
      2'd2: return 60*BASE; default: return 80*BASE; endcase
  endfunction
  function automatic int low_of(input logic [1:0] r);
    return per_of(r) / 5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // s < 0: no stop. Returns via checks only.
  task automatic run_erase(input logic [1:0] rate, input int page, input int s,
                           input bit flip_rate, input bit extra_erase);
    int p = per_of(rate), l = low_of(rate);
    int m_ovf = LASTP - page + 1, m_stop, m, tend;
    bit is_eom;
    m_stop = (s + 1 + p - 1) / p;
    if (m_stop < 1) m_stop = 1;
    is_eom = (s >= 0) && (m_stop <= m_ovf);
    m = is_eom ? m_stop : m_ovf;
    tend = m * p;
    rate_sel = rate;
    erase_addr = {PAGE_W'(page), BLK_W'($urandom)};
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    chk(busy === 1'b1, "R2 busy after erase", busy, 1);
    chk(cur_row === PAGE_W'(page), "R2 start row", cur_row, page);
    if (s == 0) stop_req = 1'b1;
    for (int k = 1; k <= tend; k++) begin
      @(negedge clk);
      stop_req = 1'b0;
      erase_req = 1'b0;
      if (k < tend) begin
        chk(busy === 1'b1, "R5 busy during erase", busy, 1);
        chk(row_clk === !((k % p) >= p - l), "R3 row clock", row_clk, !((k % p) >= p - l));
        chk(cur_row === PAGE_W'(page + k / p), "R4 row advance", cur_row, page + k / p);
      end
      if (k == s) stop_req = 1'b1;
      if (flip_rate && k == 1) rate_sel = ~rate;
      if (extra_erase && k == 3) begin
        erase_req = 1'b1;
        erase_addr = {PAGE_W'(page + 7), BLK_W'(0)};
      end
    end
    chk(busy === 1'b0, is_eom ? "R5 busy falls" : "R6 busy falls", busy, 0);
    chk(row_clk === 1'b1, "R3 idle high", row_clk, 1);
    chk(cur_row === PAGE_W'(page + m - 1), is_eom ? "R5 last row" : "R6 last row", cur_row, page + m - 1);
    chk(int_n === 1'b0, is_eom ? "R5 int low" : "R6 int low", int_n, 0);
    chk(flag_eom === is_eom, "R5 eom flag", flag_eom, is_eom);
    chk(flag_ovf === !is_eom, "R6 ovf flag", flag_ovf, !is_eom);
    repeat (3) @(negedge clk);
    chk(int_n === 1'b0, "R7 int held", int_n, 0);
    stop_req = 1'b1;             // ignored while idle (R8)
    @(negedge clk);
    stop_req = 1'b0;
    chk(busy === 1'b0, "R8 idle stop ignored", busy, 0);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    chk(int_n === 1'b1 && !flag_eom && !flag_ovf, "R7 status clears", int_n, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && row_clk === 1'b1 && int_n === 1'b1, "R1 reset outputs",
        {busy, row_clk, int_n}, 3'b011);
    chk(cur_row === '0 && !flag_eom && !flag_ovf, "R1 reset row and flags", cur_row, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners
    run_erase(2'd0, 3, 39, 1'b0, 1'b0);    // stop in last cycle of row: R5
    run_erase(2'd0, 3, 40, 1'b0, 1'b0);    // stop at first cycle of next row: R5
    run_erase(2'd3, LASTP, -1, 1'b0, 1'b0); // overflow on first row: R6
    run_erase(2'd1, LASTP - 1, 60, 1'b1, 1'b0); // stop in last row beats overflow: R6
    run_erase(2'd2, 13, -1, 1'b1, 1'b1);   // late erase ignored, overflow: R8
    // Random
    for (int i = 0; i < 30; i++) begin
      logic [1:0] r = 2'($urandom);
      int pg = int'($urandom_range(0, LASTP));
      int s = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, 3 * per_of(r)));
      run_erase(r, pg, s, 1'($urandom), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule